// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block takes eight level-sensitive shared interrupt lines (lines A to H) and one power-management event line (the SCI). It fans them out to two output spaces. The first is a bank of sixteen legacy controller inputs. The second is a set of advanced controller inputs, here called GSI, numbered 0 up to sixteen plus the line count.

Each shared line has a routing byte that picks one legacy input, or keeps the line off the legacy bank entirely. The advanced mapping is fixed: line n always drives GSI 16+n, and no two lines share a GSI. A small select field sends the SCI to one of five targets. Three of those targets lie in the legacy range and so appear in both spaces; the other two exist only in the GSI space. Every output is the logical OR of all sources routed to it at that moment.

Configuration is written through a plain one-cycle write strobe with an address and a data byte. There is no data stream at the block edge, so no valid/ready handshake applies. All outputs are registered.

Top module: `irq_line_router`

## Requirements
- R1: While reset is held, and on the first edge after it, every output is low. Reset loads every routing byte with 0x80, which means the line is kept off the legacy bank. It also loads the SCI select with 0, which means IRQ 9.
- R2: A write with address 0 to 3 loads the routing byte of lines A to D. Address 4 to 7 loads lines E to H. Address 8 loads the SCI select from data bits 2:0. Any other address changes nothing. The outputs reflect a write from the second rising edge after the strobe was presented; at the first edge they still follow the old setting.
- R3: A routing byte uses bit 7 as the off bit and bits 3:0 as the legacy input number. A line whose off bit is clear and whose level is high drives legacy input number bits 3:0.
- R4: A line whose off bit is set drives no legacy input, whatever its level and number bits.
- R5: Each legacy input is the OR of every active line routed to it, plus the SCI when the SCI targets that input.
- R6: Line n drives GSI 16+n whenever its level is high. This holds whatever its routing byte says, including the off bit.
- R7: SCI select codes 0, 1, 2, 3 and 4 send the SCI level to GSI 9, 10, 11, 20 and 21 respectively.
- R8: The SCI also drives the legacy input of the same number only for the targets below 16, that is codes 0 to 2. Codes 3 and 4 leave the legacy bank untouched.
- R9: SCI select codes 5, 6 and 7 are reserved. With any of them the SCI drives no output at all.
- R10: A change of a line level or of the SCI level reaches the outputs at the next rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| pirq_lvl | input | 8 | Levels of shared lines A (bit 0) to H (bit 7) |
| sci_lvl | input | 1 | Level of the power-management event line |
| legacy_irq | output | 16 | Registered legacy controller input levels |
| gsi_irq | output | 24 | Registered advanced controller input levels |

## Verification
The assertions assume that every input is a settled 0 or 1 level at each rising edge. They also assume that the inputs are driven low while reset is held, because the first post-reset output still shows the reset value. Across that edge, the checker tracks the sources with a one-cycle history flag only after one clean cycle out of reset.

The stimulus changes inputs only on falling edges and keeps them low through reset. Writes go to both valid and unused addresses with arbitrary data, so reserved SCI codes and off-bit settings arise naturally. The stimulus never violates these assumptions.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int ROUTE_W   = 8;
  localparam int OFF_BIT   = 7;
  localparam int LEG_SEL_W = 4;
  localparam int SCI_SEL_W = 3;
  localparam int SCI_NUM_W = 5;

  typedef struct packed {
    logic                 hit;
    logic [SCI_NUM_W-1:0] num;
  } sci_tgt_t;

  function automatic sci_tgt_t sci_decode(input logic [SCI_SEL_W-1:0] sel);
    sci_tgt_t t;
    t.hit = 1'b1;
    t.num = '0;
    case (sel)
      3'd0:    t.num = 5'd9;
      3'd1:    t.num = 5'd10;
      3'd2:    t.num = 5'd11;
      3'd3:    t.num = 5'd20;
      3'd4:    t.num = 5'd21;
      default: t.hit = 1'b0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_router_pkg::*;
#(
  parameter int                   N_LINES   = 8,
  parameter int                   ADDR_W    = 4,
  parameter logic [ROUTE_W-1:0]   ROUTE_RST = 8'h80,
  parameter logic [SCI_SEL_W-1:0] SCI_RST   = 3'd0
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 we,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [ROUTE_W-1:0]                   wdata,
  output logic [N_LINES-1:0]                   line_off,
  output logic [N_LINES-1:0][LEG_SEL_W-1:0]    line_sel,
  output logic [SCI_SEL_W-1:0]                 sci_sel
);

  localparam logic [ADDR_W-1:0] SCI_ADDR = ADDR_W'(N_LINES);

  // bits between the off bit and the number field carry no meaning
  logic unused_gap;
  assign unused_gap = ^wdata[OFF_BIT-1:LEG_SEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_LINES; i++) begin
        line_off[i] <= ROUTE_RST[OFF_BIT];
        line_sel[i] <= ROUTE_RST[LEG_SEL_W-1:0];
      end
      sci_sel <= SCI_RST;
    end else if (we) begin
      for (int i = 0; i < N_LINES; i++) begin
        if (addr == ADDR_W'(i)) begin
          line_off[i] <= wdata[OFF_BIT];
          line_sel[i] <= wdata[LEG_SEL_W-1:0];
        end
      end
      if (addr == SCI_ADDR) sci_sel <= wdata[SCI_SEL_W-1:0];
    end
  end

endmodule

// File: rtl/irq_legacy_merge.sv
module irq_legacy_merge
  import irq_router_pkg::*;
#(
  parameter int N_LINES  = 8,
  parameter int N_LEGACY = 16
) (
  input  logic [N_LINES-1:0]                line_off,
  input  logic [N_LINES-1:0][LEG_SEL_W-1:0] line_sel,
  input  logic [N_LINES-1:0]                pirq_lvl,
  input  logic                              sci_lvl,
  input  sci_tgt_t                          sci_tgt,
  output logic [N_LEGACY-1:0]               leg_nxt
);

  for (genvar k = 0; k < N_LEGACY; k++) begin : g_leg
    always_comb begin
      logic acc;
      acc = sci_lvl && sci_tgt.hit && (sci_tgt.num == SCI_NUM_W'(k));
      for (int n = 0; n < N_LINES; n++) begin
        if (pirq_lvl[n] && !line_off[n] && (line_sel[n] == LEG_SEL_W'(k)))
          acc = 1'b1;
      end
      leg_nxt[k] = acc;
    end
  end

endmodule

// File: rtl/irq_gsi_merge.sv
module irq_gsi_merge
  import irq_router_pkg::*;
#(
  parameter int N_LINES  = 8,
  parameter int N_LEGACY = 16,
  parameter int N_GSI    = N_LEGACY + N_LINES
) (
  input  logic [N_LINES-1:0] pirq_lvl,
  input  logic               sci_lvl,
  input  sci_tgt_t           sci_tgt,
  output logic [N_GSI-1:0]   gsi_nxt
);

  for (genvar g = 0; g < N_GSI; g++) begin : g_gsi
    logic sci_here;
    assign sci_here = sci_lvl && sci_tgt.hit && (sci_tgt.num == SCI_NUM_W'(g));
    if (g >= N_LEGACY) begin : g_line
      assign gsi_nxt[g] = sci_here | pirq_lvl[g-N_LEGACY];
    end else begin : g_only_sci
      assign gsi_nxt[g] = sci_here;
    end
  end

endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
  import irq_router_pkg::*;
#(
  parameter int                   NUM_LINES = 8,
  parameter int                   ADDR_W    = 4,
  parameter logic [ROUTE_W-1:0]   ROUTE_RST = 8'h80,
  parameter logic [SCI_SEL_W-1:0] SCI_RST   = 3'd0,
  localparam int                  NUM_LEGACY = 2 ** LEG_SEL_W,
  localparam int                  NUM_GSI    = NUM_LEGACY + NUM_LINES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [ROUTE_W-1:0]    cfg_wdata,
  input  logic [NUM_LINES-1:0]  pirq_lvl,
  input  logic                  sci_lvl,
  output logic [NUM_LEGACY-1:0] legacy_irq,
  output logic [NUM_GSI-1:0]    gsi_irq
);

  logic [NUM_LINES-1:0]                line_off;
  logic [NUM_LINES-1:0][LEG_SEL_W-1:0] line_sel;
  logic [SCI_SEL_W-1:0]                sci_sel;
  sci_tgt_t                            sci_tgt;
  logic [NUM_LEGACY-1:0]               leg_nxt;
  logic [NUM_GSI-1:0]                  gsi_nxt;

  irq_route_regs #(
    .N_LINES  (NUM_LINES),
    .ADDR_W   (ADDR_W),
    .ROUTE_RST(ROUTE_RST),
    .SCI_RST  (SCI_RST)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .line_off(line_off),
    .line_sel(line_sel),
    .sci_sel (sci_sel)
  );

  assign sci_tgt = sci_decode(sci_sel);

  irq_legacy_merge #(
    .N_LINES (NUM_LINES),
    .N_LEGACY(NUM_LEGACY)
  ) u_leg (
    .line_off(line_off),
    .line_sel(line_sel),
    .pirq_lvl(pirq_lvl),
    .sci_lvl (sci_lvl),
    .sci_tgt (sci_tgt),
    .leg_nxt (leg_nxt)
  );

  irq_gsi_merge #(
    .N_LINES (NUM_LINES),
    .N_LEGACY(NUM_LEGACY),
    .N_GSI   (NUM_GSI)
  ) u_gsi (
    .pirq_lvl(pirq_lvl),
    .sci_lvl (sci_lvl),
    .sci_tgt (sci_tgt),
    .gsi_nxt (gsi_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      legacy_irq <= '0;
      gsi_irq    <= '0;
    end else begin
      legacy_irq <= leg_nxt;
      gsi_irq    <= gsi_nxt;
    end
  end

endmodule

// File: rtl/irq_line_router_chk.sv
module irq_line_router_chk #(
  parameter int NUM_LINES  = 8,
  parameter int NUM_LEGACY = 16,
  parameter int NUM_GSI    = 24
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_LINES-1:0]  pirq_lvl,
  input logic                  sci_lvl,
  input logic [2:0]            sci_sel,
  input logic [NUM_LEGACY-1:0] legacy_irq,
  input logic [NUM_GSI-1:0]    gsi_irq
);

  logic hist_ok;
  always_ff @(posedge clk) begin
    if (rst) hist_ok <= 1'b0;
    else     hist_ok <= 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (legacy_irq == '0 && gsi_irq == '0)); // R1

  AST_LINE_TO_OWN_GSI: assert property (@(posedge clk) disable iff (rst)
    hist_ok |-> ((gsi_irq[NUM_LEGACY +: NUM_LINES] & $past(pirq_lvl)) == $past(pirq_lvl))); // R6

  AST_LOW_GSI_NEEDS_SCI: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && (gsi_irq[NUM_LEGACY-1:0] != '0)) |-> $past(sci_lvl)); // R7

  AST_NO_SOURCE_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && $past(pirq_lvl) == '0 && !$past(sci_lvl)) |-> (legacy_irq == '0 && gsi_irq == '0)); // R10

  AST_SCI_HIGH_TARGET: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && $past(sci_lvl) && $past(sci_sel) == 3'd3) |-> gsi_irq[20]); // R7

  AST_SCI_HIGH_NOT_LEGACY: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && $past(pirq_lvl) == '0 && $past(sci_sel) == 3'd4) |-> (legacy_irq == '0)); // R8

  AST_SCI_RESERVED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && $past(pirq_lvl) == '0 && $past(sci_sel) >= 3'd5) |-> (gsi_irq == '0 && legacy_irq == '0)); // R9

endmodule

bind irq_line_router irq_line_router_chk #(
  .NUM_LINES (NUM_LINES),
  .NUM_LEGACY(NUM_LEGACY),
  .NUM_GSI   (NUM_GSI)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pirq_lvl  (pirq_lvl),
  .sci_lvl   (sci_lvl),
  .sci_sel   (sci_sel),
  .legacy_irq(legacy_irq),
  .gsi_irq   (gsi_irq)
);

// File: tb/irq_line_router_bench.sv
`timescale 1ns/1ps
module irq_line_router_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  pirq_lvl = '0;
  logic        sci_lvl = 1'b0;
  logic [15:0] legacy_irq;
  logic [23:0] gsi_irq;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_route [8];
  logic [2:0] m_sci;

  always #2.5 clk = ~clk;

  irq_line_router u_irq_line_router (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pirq_lvl(pirq_lvl), .sci_lvl(sci_lvl),
    .legacy_irq(legacy_irq), .gsi_irq(gsi_irq)
  );

  function automatic logic [15:0] exp_leg(input logic [7:0] p, input logic s);
    logic [15:0] r = '0;
    for (int n = 0; n < 8; n++)
      if (p[n] && !m_route[n][7]) r[m_route[n][3:0]] = 1'b1;
    case (m_sci)
      3'd0: r[9]  = r[9]  | s;
      3'd1: r[10] = r[10] | s;
      3'd2: r[11] = r[11] | s;
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [23:0] exp_gsi(input logic [7:0] p, input logic s);
    logic [23:0] r = '0;
    r[23:16] = p;
    case (m_sci)
      3'd0: r[9]  = s;
      3'd1: r[10] = s;
      3'd2: r[11] = s;
      3'd3: r[20] = r[20] | s;
      3'd4: r[21] = r[21] | s;
      default: ;
    endcase
    return r;
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 4'd8) m_route[a[2:0]] = d;
    else if (a == 4'd8) m_sci = d[2:0];
  endtask

  task automatic drive_check(input string req, input logic [7:0] p, input logic s);
    @(negedge clk);
    pirq_lvl = p; sci_lvl = s;
    @(negedge clk);
    chk({req, " legacy"}, {8'h0, legacy_irq}, {8'h0, exp_leg(p, s)});
    chk({req, " gsi"}, gsi_irq, exp_gsi(p, s));
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7711));
    for (int i = 0; i < 8; i++) m_route[i] = 8'h80;
    m_sci = 3'd0;
    repeat (3) @(negedge clk);
    chk("R1 reset legacy", {8'h0, legacy_irq}, 24'h0);
    chk("R1 reset gsi", gsi_irq, 24'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first edge gsi", gsi_irq, 24'h0);

    // R1 R4 R6: all lines off the legacy bank after reset, GSI still fed
    drive_check("R4", 8'hFF, 1'b0);
    drive_check("R1 sci default", 8'h00, 1'b1);

    // R2 timing of a routing write
    drive_check("R3 pre", 8'h01, 1'b0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 8'h05;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R2 old setting at first edge", {8'h0, legacy_irq}, 24'h0);
    m_route[0] = 8'h05;
    @(negedge clk);
    chk("R2 new setting at second edge", {8'h0, legacy_irq}, 24'h000020);

    // R10 input change waits for the edge
    @(negedge clk);
    pirq_lvl = 8'h00;
    #1;
    chk("R10 before edge", {8'h0, legacy_irq}, 24'h000020);
    @(negedge clk);
    chk("R10 after edge", {8'h0, legacy_irq}, 24'h0);

    // R2 unused address ignored
    cfg_write(4'hF, 8'h03);
    cfg_write(4'h9, 8'h03);
    drive_check("R2 unused addr", 8'h01, 1'b1);

    // R5 sharing, R4 off bit with a matching number
    cfg_write(4'd1, 8'h05);
    cfg_write(4'd2, 8'h85);
    cfg_write(4'd6, 8'h0B);
    drive_check("R5 share", 8'h06, 1'b0);
    drive_check("R5 share b", 8'h02, 1'b0);
    drive_check("R4 off line", 8'h04, 1'b0);
    drive_check("R3 group two", 8'h40, 1'b0);

    // R7 R8 R9 SCI targets
    cfg_write(4'd8, 8'h02);
    drive_check("R5 sci with line", 8'h40, 1'b1);
    cfg_write(4'd8, 8'h03);
    drive_check("R8 sci 20", 8'h00, 1'b1);
    cfg_write(4'd8, 8'h04);
    drive_check("R7 sci 21", 8'h20, 1'b1);
    cfg_write(4'd8, 8'h01);
    drive_check("R7 sci 10", 8'h00, 1'b1);
    cfg_write(4'd8, 8'hF6);
    drive_check("R9 reserved", 8'h00, 1'b1);
    cfg_write(4'd8, 8'h05);
    drive_check("R9 reserved b", 8'h00, 1'b1);

    // random mix
    for (int it = 0; it < 400; it++) begin
      if (($urandom % 3) != 0) begin
        logic [3:0] a;
        a = ($urandom % 4 == 0) ? 4'(9 + $urandom % 7) : 4'($urandom % 9);
        cfg_write(a, 8'($urandom));
      end
      drive_check("RND R3 R5 R6 R7", 8'($urandom), 1'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule